// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block chooses which of a set of interrupt request lines the processor should service next, and when. It works on request flags that are already latched upstream. Each line is gated by its own enable bit and by one shared enable bit. Each line also carries a two-bit priority that places it on one of four levels. Arbitration happens only on a cycle-start strobe. The winner is the pending line on the highest level. When several pending lines share that level, the line with the smallest index wins.

The controller records which levels currently have a service routine in progress, using one bit per level. A new request is raised only when its level is strictly above the running level, which is the highest level in service. A request may also be raised when nothing is in service. When the processor acknowledges, the granted level is marked as in service and the request drops. When the processor returns from a routine, the highest in-service mark is cleared. This lets the next lower routine resume as the running level.

Top module: `nested_irq_ctrl`

## Requirements
- R1: A line is considered only if its pending flag, its own enable bit and the shared enable bit are all 1. If no line qualifies, a strobe leaves `irq_req` at 0.
- R2: A line's level is {`prio_hi`, `prio_lo`}. 2'b00 is level 0, the lowest. 2'b01 is level 1, 2'b10 is level 2 and 2'b11 is level 3, the highest. The level of the raised request appears on `irq_lvl`.
- R3: When qualifying lines sit on different levels, the line on the highest level is raised.
- R4: When several qualifying lines share the highest level, the one with the smallest index is raised, and its index appears on `irq_id`.
- R5: `irq_req`, `irq_id` and `irq_lvl` change only in the cycle after a `cyc_start` pulse. The one exception is the drop caused by an acknowledge. Changes to the inputs between strobes have no effect on the outputs.
- R6: When `ack` is high while `irq_req` is high, the level on `irq_lvl` is marked in service and `irq_req` is 0 in the next cycle.
- R7: While a routine is in service, a strobe raises a request only if the winning level is strictly above the running level. A winner on an equal or lower level leaves `irq_req` at 0.
- R8: While level 3 is in service, no line raises a request.
- R9: A `reti` pulse clears the highest in-service level, so the next lower in-service level becomes the running level.
- R10: Clearing the shared enable or a line enable does not change which levels are in service.
- R11: After reset `irq_req` is 0 and no level is in service, so a level-0 line can be raised at the first strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pend | input | N_SRC | Latched request flags, one per line |
| src_en | input | N_SRC | Per-line enable bits |
| glb_en | input | 1 | Shared enable for all lines |
| prio_hi | input | N_SRC | High bit of each line's level |
| prio_lo | input | N_SRC | Low bit of each line's level |
| cyc_start | input | 1 | Cycle-start strobe; arbitration happens here |
| ack | input | 1 | Processor accepts the raised request |
| reti | input | 1 | Processor ends the running routine |
| irq_req | output | 1 | Request to the processor |
| irq_id | output | $clog2(N_SRC) | Index of the raised line |
| irq_lvl | output | 2 | Level of the raised line |

## Verification
The selection logic is tried with several pending sets. A single line is set on each of the four level codes in turn, which confirms how the level bits are decoded. A low-index line on a low level competes with a high-index line on a high level, which shows whether level outranks index. Three lines on one level show whether index alone breaks the tie. A stack of nested acknowledges followed by returns, checked against equal, lower and higher candidates, separates the strict comparison from a greater-or-equal one. It also shows whether a return clears the highest in-service mark or some other one.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 1 << LVL_W;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/nic_arb.sv
module nic_arb
  import nic_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDW  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]            eff,
  input  logic [N_SRC-1:0][LVL_W-1:0] prio,
  output logic                        win_vld,
  output logic [IDW-1:0]              win_id,
  output lvl_t                        win_lvl
);
  // Scan from the top index down; ">=" lets a smaller index take over a tie.
  always_comb begin
    win_vld = 1'b0;
    win_id  = '0;
    win_lvl = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (eff[i] && (!win_vld || prio[i] >= win_lvl)) begin
        win_vld = 1'b1;
        win_id  = IDW'(i);
        win_lvl = prio[i];
      end
    end
  end
endmodule

// File: rtl/nic_isr.sv
module nic_isr
  import nic_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  lvl_t push_lvl,
  input  logic pop,
  output logic busy,
  output lvl_t run_lvl
);
  logic [NUM_LVL-1:0] isr_q, isr_d, top_oh;

  always_comb begin
    top_oh  = '0;
    run_lvl = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (isr_q[l]) begin
        top_oh  = '0;
        top_oh[l] = 1'b1;
        run_lvl = lvl_t'(l);
      end
    end
    busy = |isr_q;
  end

  always_comb begin
    isr_d = isr_q;
    if (pop) isr_d = isr_d & ~top_oh;
    if (push) isr_d[push_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else if (push || pop) isr_q <= isr_d;
  end

  // R6
  push_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> isr_q[$past(push_lvl)]);

  // R9
  pop_clears_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && busy) |=> !isr_q[$past(run_lvl)]);

  // R10
  isr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> $countones(isr_q) <= $past($countones(isr_q)));
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
  import nic_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDW  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_pend,
  input  logic [N_SRC-1:0] src_en,
  input  logic             glb_en,
  input  logic [N_SRC-1:0] prio_hi,
  input  logic [N_SRC-1:0] prio_lo,
  input  logic             cyc_start,
  input  logic             ack,
  input  logic             reti,
  output logic             irq_req,
  output logic [IDW-1:0]   irq_id,
  output logic [1:0]       irq_lvl
);
  logic [N_SRC-1:0]            eff;
  logic [N_SRC-1:0][LVL_W-1:0] prio;
  logic                        win_vld, busy, raise, accept, upd;
  logic [IDW-1:0]              win_id, id_q, id_d;
  lvl_t                        win_lvl, run_lvl, lvl_q, lvl_d;
  logic                        req_q, req_d;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign eff[g]  = irq_pend[g] & src_en[g] & glb_en;
    assign prio[g] = {prio_hi[g], prio_lo[g]};
  end

  nic_arb #(.N_SRC(N_SRC)) u_arb (
    .eff(eff), .prio(prio),
    .win_vld(win_vld), .win_id(win_id), .win_lvl(win_lvl)
  );

  nic_isr u_isr (
    .clk(clk), .rst_n(rst_n),
    .push(accept), .push_lvl(lvl_q), .pop(reti),
    .busy(busy), .run_lvl(run_lvl)
  );

  // Next state
  always_comb begin
    raise  = win_vld && (!busy || win_lvl > run_lvl);
    accept = ack && req_q;
    upd    = cyc_start && !accept && raise;
    req_d  = req_q;
    id_d   = id_q;
    lvl_d  = lvl_q;
    if (accept) req_d = 1'b0;
    else if (cyc_start) req_d = raise;
    if (upd) begin
      id_d  = win_id;
      lvl_d = win_lvl;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      id_q  <= '0;
      lvl_q <= '0;
    end else begin
      req_q <= req_d;
      if (upd) begin
        id_q  <= id_d;
        lvl_q <= lvl_d;
      end
    end
  end

  assign irq_req = req_q;
  assign irq_id  = id_q;
  assign irq_lvl = lvl_q;

  // R7
  strict_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && busy) |-> (irq_lvl > run_lvl));

  // R8
  top_level_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_lvl == 2'd3) |-> !irq_req);

  // R6
  ack_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req) |=> !irq_req);

  // R5
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |=> ($stable(irq_id) && $stable(irq_lvl) && !$rose(irq_req)));
endmodule

// File: tb/nested_irq_ctrl_test.sv
module nested_irq_ctrl_test;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] irq_pend, src_en, prio_hi, prio_lo;
  logic glb_en, cyc_start, ack, reti;
  logic irq_req;
  logic [2:0] irq_id;
  logic [1:0] irq_lvl;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  nested_irq_ctrl #(.N_SRC(N)) uut (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .src_en(src_en),
    .glb_en(glb_en), .prio_hi(prio_hi), .prio_lo(prio_lo),
    .cyc_start(cyc_start), .ack(ack), .reti(reti),
    .irq_req(irq_req), .irq_id(irq_id), .irq_lvl(irq_lvl)
  );

  task automatic expect_out(string r, logic er, int eid, int elv);
    tests++;
    if (irq_req !== er || (er && (irq_id !== 3'(eid) || irq_lvl !== 2'(elv)))) begin
      fails++;
      $display("FAIL %s: actual req=%0b id=%0d lvl=%0d expected req=%0b id=%0d lvl=%0d",
               r, irq_req, irq_id, irq_lvl, er, eid, elv);
    end
  endtask

  task automatic set_lvl(int s, int l);
    prio_hi[s] = l[1];
    prio_lo[s] = l[0];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq_pend = '0; src_en = '1; glb_en = 1'b1;
    prio_hi = '0; prio_lo = '0; cyc_start = 1'b0; ack = 1'b0; reti = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic strobe();
    cyc_start = 1'b1; @(negedge clk); cyc_start = 1'b0; @(negedge clk);
  endtask

  task automatic do_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0; @(negedge clk);
  endtask

  task automatic do_reti();
    reti = 1'b1; @(negedge clk); reti = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    expect_out("R11 reset", 1'b0, 0, 0);
  endtask

  task automatic t_enables();
    do_reset();
    irq_pend[3] = 1'b1; glb_en = 1'b0; strobe();
    expect_out("R1 shared enable off", 1'b0, 0, 0);
    glb_en = 1'b1; src_en[3] = 1'b0; strobe();
    expect_out("R1 line enable off", 1'b0, 0, 0);
    src_en[3] = 1'b1; strobe();
    expect_out("R11 level 0 raised when idle", 1'b1, 3, 0);
  endtask

  task automatic t_levels();
    for (int l = 0; l < 4; l++) begin
      do_reset();
      set_lvl(5, l); irq_pend[5] = 1'b1; strobe();
      expect_out("R2 level code", 1'b1, 5, l);
    end
  endtask

  task automatic t_highest();
    do_reset();
    set_lvl(1, 1); set_lvl(6, 3); irq_pend[1] = 1'b1; irq_pend[6] = 1'b1; strobe();
    expect_out("R3 highest level wins", 1'b1, 6, 3);
  endtask

  task automatic t_rank();
    do_reset();
    set_lvl(2, 2); set_lvl(4, 2); set_lvl(7, 2); set_lvl(0, 1);
    irq_pend = 8'b1001_0101; strobe();
    expect_out("R4 smallest index wins tie", 1'b1, 2, 2);
  endtask

  task automatic t_strobe_only();
    do_reset();
    irq_pend[4] = 1'b1; repeat (3) @(negedge clk);
    expect_out("R5 no strobe no request", 1'b0, 0, 0);
    strobe();
    expect_out("R5 strobe raises", 1'b1, 4, 0);
    irq_pend = 8'b0000_0010; set_lvl(1, 3); repeat (3) @(negedge clk);
    expect_out("R5 outputs held between strobes", 1'b1, 4, 0);
  endtask

  task automatic t_nesting();
    do_reset();
    set_lvl(4, 1); irq_pend[4] = 1'b1; strobe(); do_ack(); irq_pend[4] = 1'b0;
    expect_out("R6 ack drops request", 1'b0, 0, 0);
    set_lvl(2, 1); irq_pend[2] = 1'b1; strobe();
    expect_out("R7 equal level blocked", 1'b0, 0, 0);
    irq_pend[2] = 1'b0; irq_pend[6] = 1'b1; strobe();
    expect_out("R7 lower level blocked", 1'b0, 0, 0);
    irq_pend[6] = 1'b0;
    glb_en = 1'b0; strobe(); glb_en = 1'b1;
    irq_pend[2] = 1'b1; strobe();
    expect_out("R10 service kept over disable", 1'b0, 0, 0);
    irq_pend[2] = 1'b0;
    set_lvl(0, 2); irq_pend[0] = 1'b1; strobe();
    expect_out("R7 higher level preempts", 1'b1, 0, 2);
    do_ack(); irq_pend[0] = 1'b0;
    set_lvl(5, 3); irq_pend[5] = 1'b1; strobe();
    expect_out("R7 level 3 preempts level 2", 1'b1, 5, 3);
    do_ack(); irq_pend[5] = 1'b0;
    set_lvl(1, 3); irq_pend[1] = 1'b1; strobe();
    expect_out("R8 level 3 not interrupted", 1'b0, 0, 0);
    do_reti(); strobe();
    expect_out("R9 return resumes level 2", 1'b1, 1, 3);
    do_ack(); irq_pend[1] = 1'b0;
    do_reti(); do_reti();
    irq_pend[2] = 1'b1; strobe();
    expect_out("R9 level 1 still running", 1'b0, 0, 0);
    do_reti(); strobe();
    expect_out("R9 all returned", 1'b1, 2, 1);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL R5 watchdog: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_enables();
    t_levels();
    t_highest();
    t_rank();
    t_strobe_only();
    t_nesting();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule